// File: doc/BRIEF.md
# Integrating Light Conversion Sequencer

This block runs the digital side of an integrating light-to-count converter. A configuration write carries a 3-bit operating mode, a 2-bit resolution code and a sensitivity range bit. The mode selects one of three colour channels and chooses between a single conversion and a repeating one. The all-zero code and the reserved code both leave the converter idle. While a conversion runs, the block opens an integration window. The window length is a power of two in oscillator ticks, and the exponent is the selected resolution. Each ticks comes from a divider on the system clock. During the window the block counts the digitised pulses that the analog modulator delivers on `pulse_in`.

When the window closes, the block stores the count, saturated at the full-scale code of the selected resolution, in the result output. It marks that update with a one-cycle strobe for the interrupt logic. A single conversion then drops back to power-down by clearing its mode. A repeating conversion starts its next window on the following cycle. Any new configuration write during a window throws that window away and starts over under the new settings. The range bit has no effect here and is handed to the analog side unchanged.

Top module: `conv_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `afe_chan_o`, `mode_o` and `data_o` are all zero.
- R2: Mode bits [1:0] pick the channel (01 red, 10 blue, 11 green) and bit 2 set means repeating. While converting, `afe_chan_o` equals mode bits [1:0]. Otherwise it is 00.
- R3: The resolution code sets n = 16 - 4*code (00→16, 01→12, 10→8, 11→4). `done_o` pulses exactly TICK_DIV*2^n clock edges after the edge that captured the write.
- R4: The result is the number of cycles with `pulse_in` high inside the window. It is right-justified, so bits at and above n are zero.
- R5: The pulse count saturates at 2^n-1 and does not wrap.
- R6: A single conversion (mode 001, 010, 011) clears `mode_o` to 000 and drops `busy_o` on the edge that raises `done_o`. No further result follows without a new write.
- R7: A repeating conversion (mode 101, 110, 111) starts its next window at once and refreshes the result every TICK_DIV*2^n cycles, while `busy_o` stays high.
- R8: `done_o` lasts one cycle and appears only with a result update. `data_o` changes at no other time.
- R9: A write during a window aborts that window without updating `data_o`. The block restarts under the new mode and resolution, or stops if the new mode is 000.
- R10: Mode 100 behaves as power-down. Nothing converts and no result appears, although `mode_o` reads 100.
- R11: `afe_range_o` takes the written range bit on the edge after any write, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_mode | input | 3 | Operating mode written on `cfg_wr` |
| cfg_res | input | 2 | Resolution code written on `cfg_wr` |
| cfg_range | input | 1 | Sensitivity range bit written on `cfg_wr` |
| pulse_in | input | 1 | Digitised modulator pulse, counted once per cycle while high |
| busy_o | output | 1 | Integration window in progress |
| afe_chan_o | output | 2 | Channel select to the analog front end, 00 when idle |
| afe_range_o | output | 1 | Range bit passed to the analog front end |
| mode_o | output | 3 | Current operating mode |
| data_o | output | MAX_W | Latest saturated, right-justified result |
| done_o | output | 1 | One-cycle result-update strobe |

## Verification
`busy_o`, `mode_o`, `afe_chan_o` and `afe_range_o` follow a write on the edge that captures it. `data_o` and `done_o` are due exactly TICK_DIV*2^n edges later. The bench drives each write on a falling edge and counts falling edges from there. For every window length it samples once, one cycle before the due edge, and expects the strobe low. It samples again right after the due edge and expects the strobe high with the predicted count. Abort and idle cases are checked at the moment the old window would have ended and across a quiet stretch afterwards.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam logic [2:0] MODE_OFF = 3'b000;

    // A mode converts only when a channel is selected in its low bits.
    function automatic logic mode_runs(input logic [2:0] m);
        return m[1:0] != 2'b00;
    endfunction

    // The top bit of the mode asks for back-to-back windows.
    function automatic logic mode_repeats(input logic [2:0] m);
        return m[2];
    endfunction

endpackage

// File: rtl/conv_tick_gen.sv
module conv_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        tick  = run && (div_q == DIV_LAST);
        div_d = div_q;
        if (clr || tick) begin
            div_d = '0;
        end else if (run) begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/conv_window.sv
module conv_window #(
    parameter int MAX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [MAX_W-1:0] limit,
    output logic             last
);
    logic [MAX_W-1:0] win_d, win_q;

    always_comb begin
        last  = tick && (win_q == limit);
        win_d = win_q;
        if (clr || last) begin
            win_d = '0;
        end else if (tick) begin
            win_d = win_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/conv_accum.sv
module conv_accum #(
    parameter int MAX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pulse_en,
    input  logic [MAX_W-1:0] limit,
    output logic [MAX_W-1:0] value_nx
);
    logic [MAX_W-1:0] acc_d, acc_q;

    always_comb begin
        // Hold at full scale instead of wrapping.
        value_nx = acc_q;
        if (pulse_en && (acc_q < limit)) begin
            value_nx = acc_q + 1'b1;
        end
        acc_d = clr ? '0 : value_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int MAX_W    = 16,
    parameter int RES_STEP = 4,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_mode,
    input  logic [1:0]       cfg_res,
    input  logic             cfg_range,
    input  logic             pulse_in,
    output logic             busy_o,
    output logic [1:0]       afe_chan_o,
    output logic             afe_range_o,
    output logic [2:0]       mode_o,
    output logic [MAX_W-1:0] data_o,
    output logic             done_o
);
    localparam logic [MAX_W-1:0] FULL_SCALE = '1;

    typedef struct packed {
        logic             run;
        logic [2:0]       mode;
        logic [1:0]       res;
        logic             range;
        logic [MAX_W-1:0] data;
        logic             done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [MAX_W-1:0] limit;
    logic             seq_clr;
    logic             tick;
    logic             win_last;
    logic             pulse_en;
    logic [MAX_W-1:0] acc_nx;
    logic [1:0]       res_cur;

    assign limit    = FULL_SCALE >> (RES_STEP * int'(st_q.res));
    assign seq_clr  = cfg_wr || !st_q.run || win_last;
    assign pulse_en = st_q.run && pulse_in;
    assign res_cur  = st_q.res;

    conv_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (seq_clr),
        .run   (st_q.run),
        .tick  (tick)
    );

    conv_window #(.MAX_W(MAX_W)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (seq_clr),
        .tick  (tick),
        .limit (limit),
        .last  (win_last)
    );

    conv_accum #(.MAX_W(MAX_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (seq_clr),
        .pulse_en (pulse_en),
        .limit    (limit),
        .value_nx (acc_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (cfg_wr) begin
            // A write always wins: the running window is discarded.
            st_d.mode  = cfg_mode;
            st_d.res   = cfg_res;
            st_d.range = cfg_range;
            st_d.run   = mode_runs(cfg_mode);
        end else if (st_q.run && win_last) begin
            st_d.data = acc_nx;
            st_d.done = 1'b1;
            if (!mode_repeats(st_q.mode)) begin
                st_d.run  = 1'b0;
                st_d.mode = MODE_OFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.run;
    assign afe_chan_o  = st_q.run ? st_q.mode[1:0] : 2'b00;
    assign afe_range_o = st_q.range;
    assign mode_o      = st_q.mode;
    assign data_o      = st_q.data;
    assign done_o      = st_q.done;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
    parameter int MAX_W    = 16,
    parameter int RES_STEP = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             busy_o,
    input logic [1:0]       afe_chan_o,
    input logic [2:0]       mode_o,
    input logic [MAX_W-1:0] data_o,
    input logic             done_o,
    input logic [1:0]       res_cur
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> done_o);

    // R4
    res_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((data_o >> (MAX_W - RES_STEP * int'(res_cur))) == '0));

    // R2
    chan_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (afe_chan_o == 2'b00));

    // R6
    once_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !busy_o) |-> (mode_o == 3'b000));

    // R10
    busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (mode_o[1:0] != 2'b00));

    // R9
    abort_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !done_o);
endmodule

bind conv_seq conv_seq_chk #(.MAX_W(MAX_W), .RES_STEP(RES_STEP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .busy_o     (busy_o),
    .afe_chan_o (afe_chan_o),
    .mode_o     (mode_o),
    .data_o     (data_o),
    .done_o     (done_o),
    .res_cur    (res_cur)
);

// File: tb/conv_seq_tb.sv
`timescale 1ns/1ps
module conv_seq_tb;
    localparam int MAX_W    = 16;
    localparam int RES_STEP = 4;
    localparam int TICK_DIV = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [2:0]       cfg_mode = 3'b000;
    logic [1:0]       cfg_res = 2'b00;
    logic             cfg_range = 1'b0;
    logic             pulse_in;
    logic             busy_o;
    logic [1:0]       afe_chan_o;
    logic             afe_range_o;
    logic [2:0]       mode_o;
    logic [MAX_W-1:0] data_o;
    logic             done_o;

    int   pmode = 0;      // 0 none, 1 every cycle, 2 every other cycle
    logic tgl = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    bit   finished = 0;

    always #2 clk = ~clk;
    always @(negedge clk) tgl <= ~tgl;
    assign pulse_in = (pmode == 1) || ((pmode == 2) && tgl);

    conv_seq #(.MAX_W(MAX_W), .RES_STEP(RES_STEP), .TICK_DIV(TICK_DIV)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_mode    (cfg_mode),
        .cfg_res     (cfg_res),
        .cfg_range   (cfg_range),
        .pulse_in    (pulse_in),
        .busy_o      (busy_o),
        .afe_chan_o  (afe_chan_o),
        .afe_range_o (afe_range_o),
        .mode_o      (mode_o),
        .data_o      (data_o),
        .done_o      (done_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] m, input logic [1:0] r, input logic rg);
        @(negedge clk);
        cfg_mode  = m;
        cfg_res   = r;
        cfg_range = rg;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
        check(tag, 32'(seen), 0);
    endtask

    function automatic int win_len(input logic [1:0] r);
        return TICK_DIV << (16 - 4 * int'(r));
    endfunction

    task automatic t_reset();
        check("R1 busy", 32'(busy_o), 0);
        check("R1 done", 32'(done_o), 0);
        check("R1 data", 32'(data_o), 0);
        check("R1 mode", 32'(mode_o), 0);
        check("R1 chan", 32'(afe_chan_o), 0);
    endtask

    // One single conversion; result and timing checked at the exact due edge.
    task automatic t_once(input logic [2:0] m, input logic [1:0] r, input int pm,
                          input int exp_data, input string tag);
        int len;
        len   = win_len(r);
        pmode = pm;
        wr(m, r, 1'b0);
        idle(len - 1);
        check({tag, " R3 not yet done"}, 32'(done_o), 0);
        check({tag, " R2 chan"}, 32'(afe_chan_o), 32'(m[1:0]));
        idle(1);
        check({tag, " R3 done on time"}, 32'(done_o), 1);
        check({tag, " R4 data"}, 32'(data_o), 32'(exp_data));
        check({tag, " R6 busy drop"}, 32'(busy_o), 0);
        check({tag, " R6 mode clear"}, 32'(mode_o), 0);
    endtask

    task automatic t_once_set();
        t_once(3'b001, 2'b11, 1, 15, "red4 R5 saturate");
        quiet(40, "R6 no further result");
        t_once(3'b010, 2'b10, 2, 128, "blue8");
        t_once(3'b011, 2'b01, 2, 2048, "green12");
        t_once(3'b001, 2'b00, 2, 32768, "red16");
    endtask

    task automatic t_repeat();
        pmode = 2;
        wr(3'b111, 2'b11, 1'b0);
        idle(15);
        check("R7 first not yet", 32'(done_o), 0);
        idle(1);
        check("R7 first done", 32'(done_o), 1);
        check("R7 first data", 32'(data_o), 8);
        check("R7 still busy", 32'(busy_o), 1);
        check("R7 mode kept", 32'(mode_o), 32'(3'b111));
        pmode = 1;
        idle(1);
        check("R8 strobe width", 32'(done_o), 0);
        idle(14);
        check("R7 second not yet", 32'(done_o), 0);
        idle(1);
        check("R7 second done", 32'(done_o), 1);
        check("R7 second data", 32'(data_o), 15);
        wr(3'b000, 2'b11, 1'b0);
        check("R9 stop busy", 32'(busy_o), 0);
    endtask

    task automatic t_abort();
        logic [MAX_W-1:0] dv;
        pmode = 2;
        wr(3'b101, 2'b11, 1'b0);
        idle(5);
        dv = data_o;
        wr(3'b101, 2'b10, 1'b0);
        idle(9);
        check("R9 old end no strobe", 32'(done_o), 0);
        check("R9 data untouched", 32'(data_o), 32'(dv));
        idle(246);
        check("R9 restart not yet", 32'(done_o), 0);
        idle(1);
        check("R9 restart done", 32'(done_o), 1);
        check("R9 restart data", 32'(data_o), 128);
        check("R9 restart chan", 32'(afe_chan_o), 1);
        wr(3'b000, 2'b10, 1'b0);
        check("R9 off busy", 32'(busy_o), 0);
        check("R9 off chan", 32'(afe_chan_o), 0);
        quiet(300, "R9 off no result");
    endtask

    task automatic t_reserved();
        logic [MAX_W-1:0] dv;
        dv = data_o;
        pmode = 1;
        wr(3'b100, 2'b11, 1'b0);
        check("R10 busy", 32'(busy_o), 0);
        check("R10 mode reads", 32'(mode_o), 4);
        check("R10 chan", 32'(afe_chan_o), 0);
        quiet(40, "R10 no result");
        check("R10 data kept", 32'(data_o), 32'(dv));
    endtask

    task automatic t_range();
        wr(3'b000, 2'b00, 1'b1);
        check("R11 range idle set", 32'(afe_range_o), 1);
        wr(3'b000, 2'b00, 1'b0);
        check("R11 range idle clear", 32'(afe_range_o), 0);
        wr(3'b010, 2'b11, 1'b1);
        check("R11 range running", 32'(afe_range_o), 1);
        check("R11 busy", 32'(busy_o), 1);
        idle(20);
        check("R11 range held", 32'(afe_range_o), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_once_set();
        t_repeat();
        t_abort();
        t_reserved();
        t_range();
        finish_run();
    end
endmodule